// File: doc/BRIEF.md
# Frame Timestamp Capture and Descriptor Packer

This block sits beside a MAC's transmit and receive paths and records the time of day at the moment a frame event is signalled. On each capture strobe it samples the running 48-bit seconds counter and 30-bit nanoseconds counter together. It decides from a per-direction 2-bit stamping mode and the frame's class whether the frame is to carry a timestamp. It then lays the kept bits out in two 32-bit words ready for a DMA engine to write back into the frame's buffer descriptor.

Only the six least significant seconds bits are kept. Two of them share the first word with the nanoseconds, and the other four sit at the bottom of the second word. Software rebuilds the full seconds value from the live counter. Along with the words, the block produces a descriptor flag word that has the valid bit at the position the selected direction's descriptor expects. It also produces a one-cycle done strobe. Frame parsing and the DMA engines are outside the block.

Top module: `tsc_stamp_capture`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, both timestamp words, the flag word, the valid output and the done output are all zero.
- R2: For a stamped frame, word 0 holds seconds bits 1..0 in bits 31:30 and nanoseconds bits 29..0 in bits 29:0.
- R3: For a stamped frame, word 1 holds seconds bits 5..2 in bits 3:0, and bits 31:4 of word 1 are zero.
- R4: The stamping mode is decoded as follows: 0 stamps no frame, 1 stamps class 2 only, 2 stamps classes 1 and 2, and 3 stamps every frame. The class codes are 0 for a non-PTP frame, 1 for a PTP general frame and 2 for a PTP event frame.
- R5: When the mode excludes the frame, the valid output is 0 and both timestamp words are zero.
- R6: The direction input selects the mode: 0 selects the transmit mode and 1 selects the receive mode. The mode of the other direction has no effect.
- R7: For a stamped transmit frame the flag word is exactly bit 23, and for a stamped receive frame it is exactly bit 2. For an unstamped frame the flag word is zero.
- R8: The done output is high in the cycle after each clock edge at which the strobe is sampled high, and low otherwise. Back-to-back strobes give done high in consecutive cycles.
- R9: Without a new strobe, the words, flag and valid outputs hold their values while the time inputs change.
- R10: Seconds and nanoseconds are both taken at the same strobe edge. Changes to the time inputs in the cycle after the strobe do not appear in the captured words.
- R11: Class code 3 is handled as a non-PTP frame, so only mode 3 stamps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_stb | input | 1 | Capture strobe at a frame event |
| cap_dir | input | 1 | 0 transmit, 1 receive |
| frame_cls | input | 2 | Frame class code |
| tod_sec | input | 48 | Running seconds counter |
| tod_ns | input | 30 | Running nanoseconds counter |
| tx_mode | input | 2 | Transmit stamping mode |
| rx_mode | input | 2 | Receive stamping mode |
| ts_word0 | output | 32 | Packed seconds low bits and nanoseconds |
| ts_word1 | output | 32 | Packed seconds bits 5..2 |
| flag_word | output | 32 | Descriptor valid flag at its direction's bit |
| ts_valid | output | 1 | Frame was stamped |
| ts_done | output | 1 | One-cycle capture-complete strobe |

## Verification
The hardest situation to produce is one where the mode of the unselected direction would give a different answer from the selected one. Every table row therefore sets the two mode inputs so that the wrong choice flips the valid bit. Hold and atomicity are checked by inverting the time inputs in the cycle right after each capture. Two strobes on adjacent edges exercise done staying high and the words being replaced without a gap.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   typedef enum logic [1:0] {
      CLS_PLAIN   = 2'd0,
      CLS_PTP_GEN = 2'd1,
      CLS_PTP_EVT = 2'd2,
      CLS_RSVD    = 2'd3
   } frame_cls_e;

   typedef enum logic [1:0] {
      STM_OFF = 2'd0,
      STM_EVT = 2'd1,
      STM_PTP = 2'd2,
      STM_ALL = 2'd3
   } stamp_mode_e;

   localparam logic DIR_TX = 1'b0;
   localparam logic DIR_RX = 1'b1;
endpackage

// File: rtl/tsc_policy.sv
module tsc_policy
   import tsc_pkg::*;
(
   input  logic       dir,
   input  logic [1:0] tx_mode,
   input  logic [1:0] rx_mode,
   input  logic [1:0] cls,
   output logic       take
);
   stamp_mode_e mode_sel;
   logic        is_evt;
   logic        is_ptp;

   always_comb begin
      mode_sel = stamp_mode_e'((dir == DIR_RX) ? rx_mode : tx_mode);
      is_evt   = (frame_cls_e'(cls) == CLS_PTP_EVT);
      // reserved class code is folded into the non-PTP case (R11)
      is_ptp   = is_evt || (frame_cls_e'(cls) == CLS_PTP_GEN);
      unique case (mode_sel)
         STM_OFF: take = 1'b0;
         STM_EVT: take = is_evt;
         STM_PTP: take = is_ptp;
         STM_ALL: take = 1'b1;
         default: take = 1'b0;
      endcase
   end
endmodule

// File: rtl/tsc_packer.sv
module tsc_packer #(
   parameter int SEC_W    = 48,
   parameter int NS_W     = 30,
   parameter int WORD_W   = 32,
   parameter int KEEP_SEC = 6
) (
   input  logic [SEC_W-1:0]  sec,
   input  logic [NS_W-1:0]   ns,
   input  logic              en,
   output logic [WORD_W-1:0] word0,
   output logic [WORD_W-1:0] word1
);
   localparam int LO_SEC = WORD_W - NS_W;
   localparam int HI_SEC = KEEP_SEC - LO_SEC;

   initial begin
      assert (NS_W < WORD_W) else $error("nanoseconds must leave room for seconds");
      assert (HI_SEC > 0 && HI_SEC <= WORD_W) else $error("kept seconds split invalid");
      assert (KEEP_SEC < SEC_W) else $error("kept seconds exceed counter");
   end

   logic [WORD_W-1:0] w0_raw;
   logic [WORD_W-1:0] w1_raw;

   always_comb begin
      w0_raw = {sec[LO_SEC-1:0], ns};
   end

   generate
      if (HI_SEC == WORD_W) begin : g_full_hi
         assign w1_raw = sec[KEEP_SEC-1:LO_SEC];
      end else begin : g_part_hi
         assign w1_raw = {{(WORD_W-HI_SEC){1'b0}}, sec[KEEP_SEC-1:LO_SEC]};
      end
   endgenerate

   assign word0 = en ? w0_raw : '0;
   assign word1 = en ? w1_raw : '0;

   logic unused_sec_top;
   assign unused_sec_top = ^sec[SEC_W-1:KEEP_SEC];
endmodule

// File: rtl/tsc_flagmap.sv
module tsc_flagmap #(
   parameter int WORD_W = 32,
   parameter int TX_BIT = 23,
   parameter int RX_BIT = 2
) (
   input  logic              valid,
   input  logic              dir,
   output logic [WORD_W-1:0] flags
);
   initial begin
      assert (TX_BIT < WORD_W && RX_BIT < WORD_W) else $error("flag bit out of word");
   end

   logic [1:0][WORD_W-1:0] per_dir;

   generate
      for (genvar d = 0; d < 2; d++) begin : g_dir
         localparam int POS = (d == 1) ? RX_BIT : TX_BIT;
         always_comb begin
            per_dir[d]      = '0;
            per_dir[d][POS] = valid && (dir == 1'(d));
         end
      end
   endgenerate

   assign flags = per_dir[0] | per_dir[1];
endmodule

// File: rtl/tsc_stamp_capture.sv
module tsc_stamp_capture #(
   parameter int SEC_W    = 48,
   parameter int NS_W     = 30,
   parameter int WORD_W   = 32,
   parameter int KEEP_SEC = 6,
   parameter int TX_BIT   = 23,
   parameter int RX_BIT   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_stb,
   input  logic              cap_dir,
   input  logic [1:0]        frame_cls,
   input  logic [SEC_W-1:0]  tod_sec,
   input  logic [NS_W-1:0]   tod_ns,
   input  logic [1:0]        tx_mode,
   input  logic [1:0]        rx_mode,
   output logic [WORD_W-1:0] ts_word0,
   output logic [WORD_W-1:0] ts_word1,
   output logic [WORD_W-1:0] flag_word,
   output logic              ts_valid,
   output logic              ts_done
);
   logic              take;
   logic [WORD_W-1:0] nxt_w0;
   logic [WORD_W-1:0] nxt_w1;
   logic [WORD_W-1:0] nxt_flag;

   tsc_policy u_policy (
      .dir     (cap_dir),
      .tx_mode (tx_mode),
      .rx_mode (rx_mode),
      .cls     (frame_cls),
      .take    (take)
   );

   tsc_packer #(
      .SEC_W    (SEC_W),
      .NS_W     (NS_W),
      .WORD_W   (WORD_W),
      .KEEP_SEC (KEEP_SEC)
   ) u_packer (
      .sec   (tod_sec),
      .ns    (tod_ns),
      .en    (take),
      .word0 (nxt_w0),
      .word1 (nxt_w1)
   );

   tsc_flagmap #(
      .WORD_W (WORD_W),
      .TX_BIT (TX_BIT),
      .RX_BIT (RX_BIT)
   ) u_flags (
      .valid (take),
      .dir   (cap_dir),
      .flags (nxt_flag)
   );

   // single capture register set: seconds and nanoseconds share one edge (R10)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts_word0  <= '0;
         ts_word1  <= '0;
         flag_word <= '0;
         ts_valid  <= 1'b0;
         ts_done   <= 1'b0;
      end else begin
         ts_done <= cap_stb;
         if (cap_stb) begin
            ts_word0  <= nxt_w0;
            ts_word1  <= nxt_w1;
            flag_word <= nxt_flag;
            ts_valid  <= take;
         end
      end
   end

   a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> ts_done);
   a_r8_done_only_after: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_stb |=> !ts_done);
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_stb |=> ($stable(ts_word0) && $stable(ts_word1) && $stable(flag_word) && $stable(ts_valid)));
   a_r5_zero_when_skipped: assert property (@(posedge clk) disable iff (!rst_n)
      !ts_valid |-> (ts_word0 == '0 && ts_word1 == '0 && flag_word == '0));
   a_r7_flag_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      ts_valid |-> ($countones(flag_word) == 1 && (flag_word[TX_BIT] || flag_word[RX_BIT])));
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ts_word1[WORD_W-1:KEEP_SEC-(WORD_W-NS_W)] == '0);
endmodule

// File: tb/tsc_stamp_capture_test.sv
module tsc_stamp_capture_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 12;

   typedef struct packed {
      logic        dir;
      logic [1:0]  cls;
      logic [1:0]  txm;
      logic [1:0]  rxm;
      logic [47:0] sec;
      logic [29:0] ns;
   } vec_t;

   // each row: the other direction's mode would give the opposite decision (R6)
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 2'd2, 2'd1, 2'd0, 48'h0000_0000_0025, 30'h1234_5678},
      '{1'b0, 2'd1, 2'd1, 2'd3, 48'h0000_1234_003A, 30'h0ABC_DEF0},
      '{1'b0, 2'd1, 2'd2, 2'd0, 48'h0000_0000_0017, 30'h3FFF_FFFF},
      '{1'b0, 2'd0, 2'd2, 2'd3, 48'h0001_0000_0001, 30'h0000_0001},
      '{1'b0, 2'd0, 2'd3, 2'd0, 48'h8000_0000_002E, 30'h2AAA_AAAA},
      '{1'b0, 2'd2, 2'd0, 2'd3, 48'h0000_0000_0033, 30'h1555_5555},
      '{1'b1, 2'd2, 2'd0, 2'd1, 48'h0000_00FF_0009, 30'h0F0F_0F0F},
      '{1'b1, 2'd1, 2'd3, 2'd1, 48'h0000_0000_003C, 30'h3C3C_3C3C},
      '{1'b1, 2'd3, 2'd3, 2'd2, 48'h0000_0000_0012, 30'h0102_0304},
      '{1'b1, 2'd3, 2'd0, 2'd3, 48'h0000_0000_0036, 30'h2468_ACE0},
      '{1'b1, 2'd0, 2'd3, 2'd0, 48'h0000_0000_0021, 30'h1111_1111},
      '{1'b1, 2'd1, 2'd0, 2'd2, 48'hFFFF_FFFF_FFFF, 30'h3FFF_FFFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_stb = 1'b0;
   logic        cap_dir = 1'b0;
   logic [1:0]  frame_cls = '0;
   logic [47:0] tod_sec = '0;
   logic [29:0] tod_ns = '0;
   logic [1:0]  tx_mode = '0;
   logic [1:0]  rx_mode = '0;
   logic [31:0] ts_word0, ts_word1, flag_word;
   logic        ts_valid, ts_done;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   tsc_stamp_capture uut (
      .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .cap_dir(cap_dir),
      .frame_cls(frame_cls), .tod_sec(tod_sec), .tod_ns(tod_ns),
      .tx_mode(tx_mode), .rx_mode(rx_mode), .ts_word0(ts_word0),
      .ts_word1(ts_word1), .flag_word(flag_word), .ts_valid(ts_valid),
      .ts_done(ts_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         fails = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // decision from R4/R6/R11
   function automatic bit exp_take(input vec_t v);
      logic [1:0] m;
      m = v.dir ? v.rxm : v.txm;
      case (m)
         2'd0: return 1'b0;
         2'd1: return v.cls == 2'd2;
         2'd2: return (v.cls == 2'd1) || (v.cls == 2'd2);
         default: return 1'b1;
      endcase
   endfunction

   task automatic check_outputs(input vec_t v, input string tag);
      bit t;
      logic [31:0] e0, e1, ef;
      t  = exp_take(v);
      e0 = t ? {v.sec[1:0], v.ns} : 32'h0;
      e1 = t ? {28'h0, v.sec[5:2]} : 32'h0;
      ef = !t ? 32'h0 : (v.dir ? 32'h0000_0004 : 32'h0080_0000);
      chk(ts_valid == t, "R4", {tag, " valid"}, 64'(ts_valid), 64'(t));
      chk(ts_word0 == e0, t ? "R2" : "R5", {tag, " word0"}, 64'(ts_word0), 64'(e0));
      chk(ts_word1 == e1, t ? "R3" : "R5", {tag, " word1"}, 64'(ts_word1), 64'(e1));
      chk(flag_word == ef, "R7", {tag, " flag"}, 64'(flag_word), 64'(ef));
   endtask

   task automatic drive(input vec_t v);
      cap_dir = v.dir; frame_cls = v.cls; tx_mode = v.txm; rx_mode = v.rxm;
      tod_sec = v.sec; tod_ns = v.ns;
   endtask

   initial begin
      vec_t a, b;
      repeat (2) @(negedge clk);
      chk(ts_word0 == 0 && ts_word1 == 0 && flag_word == 0 && !ts_valid && !ts_done,
          "R1", "in reset", 64'(ts_word0), 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(ts_word0 == 0 && ts_word1 == 0, "R1", "words after reset", 64'(ts_word0 | ts_word1), 64'h0);
      chk(flag_word == 0 && !ts_valid && !ts_done, "R1", "flags after reset", 64'(flag_word), 64'h0);

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VECS[i]);
         cap_stb = 1'b1;
         @(negedge clk);
         cap_stb = 1'b0;
         chk(ts_done == 1'b1, "R8", "done after strobe", 64'(ts_done), 64'h1);
         check_outputs(VECS[i], "table");
         // R10/R9: scramble time and modes after the capture edge
         tod_sec = ~tod_sec; tod_ns = ~tod_ns; tx_mode = 2'd3; rx_mode = 2'd3;
         @(negedge clk);
         chk(ts_done == 1'b0, "R8", "done single pulse", 64'(ts_done), 64'h0);
         check_outputs(VECS[i], "R9 hold");
      end

      // back-to-back strobes on adjacent edges (R8, R10)
      a = VECS[0];
      b = VECS[11];
      @(negedge clk);
      drive(a);
      cap_stb = 1'b1;
      @(negedge clk);
      chk(ts_done == 1'b1, "R8", "first of pair", 64'(ts_done), 64'h1);
      check_outputs(a, "R10 pair first");
      drive(b);
      @(negedge clk);
      cap_stb = 1'b0;
      chk(ts_done == 1'b1, "R8", "second of pair", 64'(ts_done), 64'h1);
      check_outputs(b, "R10 pair second");
      @(negedge clk);
      chk(ts_done == 1'b0, "R8", "after pair", 64'(ts_done), 64'h0);

      // reserved class stamped only in mode 3 (R11)
      a = '{1'b0, 2'd3, 2'd2, 2'd3, 48'h0000_0000_003F, 30'h0000_00AA};
      @(negedge clk);
      drive(a);
      cap_stb = 1'b1;
      @(negedge clk);
      cap_stb = 1'b0;
      chk(ts_valid == 1'b0, "R11", "reserved class mode 2", 64'(ts_valid), 64'h0);

      // reset mid-run clears held stamp (R1)
      a = VECS[0];
      @(negedge clk);
      drive(a);
      cap_stb = 1'b1;
      @(negedge clk);
      cap_stb = 1'b0;
      rst_n = 1'b0;
      #1;
      chk(ts_word0 == 0 && !ts_valid && flag_word == 0 && !ts_done, "R1", "mid-run reset",
          64'(ts_word0), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule